// File: doc/BRIEF.md
# ARINC 429 Transmit Sequencer

This block turns queued 32-bit words into the three-level return-to-zero symbol stream of an ARINC 429 transmitter. A host writes each word as two 16-bit halves. It strobes the lower half first and then the upper half. The second strobe commits the assembled word into a 32-entry first-in first-out queue. Three flags report the queue state to the host: a ready flag, an active-low half-full flag and a full flag.

When transmission is enabled, the sequencer takes the oldest word from the queue and sends it least-significant bit first. Each bit drives its data level for the first half of the bit period. It holds the line at NULL for the second half. After the 32nd bit, the sequencer inserts a fixed NULL gap before it starts the next word. Two data rates are available: a fast rate with a 10-clock bit and a slow rate with an 80-clock bit. The top bit of each word can carry data, or it can be replaced by an odd or even parity bit. A test input forces the line to NULL. The sequencer outputs are two digital drive signals, one for the A side of the line driver and one for the B side.

Top module: `a429_tx_seq`

## Requirements
- R1: A `wr_lo` strobe captures `wr_data` as word bits [15:0] (ARINC bits 1–16). A later `wr_hi` strobe commits the word with `wr_data` as bits [31:16]. A `wr_hi` strobe without a captured lower half is ignored.
- R2: The queue holds 32 words. `full` is high while 32 words are stored, and any commit made while `full` is high is dropped.
- R3: `half_full_n` is low while 16 or more words are stored, and high otherwise.
- R4: `ready` is high after reset. It goes low in the cycle after a commit. It returns high only when the queue is empty and the word gap after the last word has finished.
- R5: With `rate_slow`=0, each bit drives data for 5 clocks and then NULL for 5 clocks. With `rate_slow`=1, the split is 40 clocks of data and 40 clocks of NULL. The rate is sampled when each word starts.
- R6: Line encoding: a ONE drives `line_a`=1 and `line_b`=0, a ZERO drives `line_a`=0 and `line_b`=1, and NULL drives both low. Word bit 0 goes out first. Both outputs are never high together.
- R7: When words are sent back to back, the NULL gap between the end of one word's 32nd bit period and the next word's first bit is 40 clocks at the fast rate and 320 clocks at the slow rate.
- R8: With `parity_en`=1, bit 31 is replaced by a parity bit. With `parity_even`=0, the count of ones over all 32 bits is odd. With `parity_even`=1, that count is even.
- R9: With `parity_en`=0, all 32 committed bits are sent unchanged.
- R10: On a clock edge where the sequencer is idle, `tx_enable` is high and the queue is not empty, the oldest word is loaded. Its first bit is on the line in the following cycle.
- R11: While `test_null` is high, both outputs are low. Word timing and queue draining continue as normal.
- R12: If `tx_enable` drops during a word, that word finishes, including its gap. The sequencer then idles, and the remaining words stay queued until `tx_enable` returns.
- R13: Reset empties the queue, discards a captured lower half and aborts any word in progress, leaving both outputs at NULL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_lo | input | 1 | Strobe: capture the lower data half |
| wr_hi | input | 1 | Strobe: supply the upper half and commit the word |
| wr_data | input | 16 | Data half being written |
| tx_enable | input | 1 | Allows words to be taken from the queue and sent |
| rate_slow | input | 1 | 0 selects the 10-clock bit, 1 selects the 80-clock bit |
| parity_en | input | 1 | 1 replaces bit 31 with parity |
| parity_even | input | 1 | Parity polarity: 0 gives odd, 1 gives even |
| test_null | input | 1 | Forces both line outputs low |
| line_a | output | 1 | A-side drive |
| line_b | output | 1 | B-side drive |
| ready | output | 1 | High when the queue is empty and the sequencer is idle |
| half_full_n | output | 1 | Low when 16 or more words are queued |
| full | output | 1 | High when 32 words are queued |

## Verification
The bound checker watches the line on every cycle. It confirms that the two drives are never high together. It confirms that the line is NULL outside the data half of a bit, while `ready` is high and under `test_null`. It also checks that the queue never holds more than its depth, that a full queue does not change while a word is being shifted, and that the half-full flag falls exactly at 16 words. Some properties need a whole word's history, and only the bench scenarios can show them. These are the exact symbol widths at both rates, the gap length between back-to-back words, the parity value, bit ordering, the dropping of commits into a full queue, and the finish-then-idle behaviour when enable drops mid-word. The bench decodes the line back into words and compares them with its own model.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_NULL = 2'd2,
        ST_GAP  = 2'd3
    } tx_state_e;

    typedef struct packed {
        logic a;
        logic b;
    } line_pair_t;

    // Replace the top bit with parity when enabled; polarity 0 = odd, 1 = even.
    function automatic logic [WORD_W-1:0] fix_parity(
        input logic [WORD_W-1:0] w,
        input logic              en,
        input logic              even
    );
        logic [WORD_W-1:0] r;
        logic              low_ones;
        r        = w;
        low_ones = ^w[WORD_W-2:0];
        if (en) begin
            r[WORD_W-1] = low_ones ^ ~even;
        end
        return r;
    endfunction

    // Map a bit value and a drive qualifier onto the differential pair.
    function automatic line_pair_t encode(input logic bit_v, input logic drive);
        line_pair_t p;
        p.a = drive & bit_v;
        p.b = drive & ~bit_v;
        return p;
    endfunction

endpackage

// File: rtl/a429_tx_loader.sv
module a429_tx_loader
    import a429_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wr_data,
    output logic              commit,
    output logic [WORD_W-1:0] word
);

    logic [HALF_W-1:0] lo_q;
    logic              pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            pend_q <= 1'b0;
        end else if (wr_lo) begin
            lo_q   <= wr_data;
            pend_q <= 1'b1;
        end else if (wr_hi) begin
            pend_q <= 1'b0;
        end
    end

    assign commit = wr_hi & pend_q;
    assign word   = {wr_data, lo_q};

endmodule

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          push_ok;
    logic          pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/a429_tx_serial.sv
module a429_tx_serial
    import a429_tx_pkg::*;
#(
    parameter int HS_DIV   = 10,
    parameter int LS_DIV   = 80,
    parameter int GAP_BITS = 4,
    localparam int HS_HALF = HS_DIV / 2,
    localparam int LS_HALF = LS_DIV / 2,
    localparam int HS_GAP  = HS_DIV * GAP_BITS,
    localparam int LS_GAP  = LS_DIV * GAP_BITS,
    localparam int MAXC    = (LS_GAP > HS_GAP) ? LS_GAP : HS_GAP,
    localparam int TW      = $clog2(MAXC + 1),
    localparam int BW      = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              rate_slow,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              test_null,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_rdata,
    output logic              fifo_pop,
    output logic              line_a,
    output logic              line_b,
    output tx_state_e         state_o
);

    tx_state_e         st;
    logic [TW-1:0]     cnt;
    logic [BW-1:0]     bit_idx;
    logic [WORD_W-1:0] shreg;
    logic              rate_q;
    logic [TW-1:0]     half_lim;
    logic [TW-1:0]     gap_lim;
    logic              start_ok;
    logic              load_now;
    line_pair_t        drv;

    assign half_lim = rate_q ? TW'(LS_HALF) : TW'(HS_HALF);
    assign gap_lim  = rate_q ? TW'(LS_GAP)  : TW'(HS_GAP);
    assign start_ok = enable & ~fifo_empty;
    assign load_now = start_ok &
                      ((st == ST_IDLE) || (st == ST_GAP && cnt == gap_lim - 1'b1));
    assign fifo_pop = load_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            rate_q  <= 1'b0;
        end else if (load_now) begin
            st      <= ST_DATA;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= fix_parity(fifo_rdata, par_en, par_even);
            rate_q  <= rate_slow;
        end else begin
            case (st)
                ST_DATA: begin
                    if (cnt == half_lim - 1'b1) begin
                        st  <= ST_NULL;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_NULL: begin
                    if (cnt == half_lim - 1'b1) begin
                        cnt <= '0;
                        if (bit_idx == BW'(WORD_W - 1)) begin
                            st <= ST_GAP;
                        end else begin
                            st      <= ST_DATA;
                            bit_idx <= bit_idx + 1'b1;
                            shreg   <= {1'b0, shreg[WORD_W-1:1]};
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (cnt == gap_lim - 1'b1) begin
                        st  <= ST_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    st  <= ST_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

    assign drv     = encode(shreg[0], (st == ST_DATA) & ~test_null);
    assign line_a  = drv.a;
    assign line_b  = drv.b;
    assign state_o = st;

endmodule

// File: rtl/a429_tx_seq.sv
module a429_tx_seq
    import a429_tx_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int HS_DIV   = 10,
    parameter int LS_DIV   = 80,
    parameter int GAP_BITS = 4,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [15:0] wr_data,
    input  logic        tx_enable,
    input  logic        rate_slow,
    input  logic        parity_en,
    input  logic        parity_even,
    input  logic        test_null,
    output logic        line_a,
    output logic        line_b,
    output logic        ready,
    output logic        half_full_n,
    output logic        full
);

    logic              commit;
    logic [WORD_W-1:0] new_word;
    logic              pop;
    logic [WORD_W-1:0] head_word;
    logic [CNT_W-1:0]  fifo_count;
    logic              fifo_empty;
    tx_state_e         tx_state;

    a429_tx_loader u_loader (
        .clk     (clk),
        .rst     (rst),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .commit  (commit),
        .word    (new_word)
    );

    a429_tx_fifo #(
        .DEPTH (DEPTH),
        .W     (WORD_W)
    ) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (commit),
        .wdata (new_word),
        .pop   (pop),
        .rdata (head_word),
        .count (fifo_count),
        .empty (fifo_empty),
        .full  (full)
    );

    a429_tx_serial #(
        .HS_DIV   (HS_DIV),
        .LS_DIV   (LS_DIV),
        .GAP_BITS (GAP_BITS)
    ) u_serial (
        .clk        (clk),
        .rst        (rst),
        .enable     (tx_enable),
        .rate_slow  (rate_slow),
        .par_en     (parity_en),
        .par_even   (parity_even),
        .test_null  (test_null),
        .fifo_empty (fifo_empty),
        .fifo_rdata (head_word),
        .fifo_pop   (pop),
        .line_a     (line_a),
        .line_b     (line_b),
        .state_o    (tx_state)
    );

    assign ready       = fifo_empty & (tx_state == ST_IDLE);
    assign half_full_n = (fifo_count < CNT_W'(DEPTH / 2));

endmodule

// File: rtl/a429_tx_checker.sv
module a429_tx_checker
    import a429_tx_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          line_a,
    input logic          line_b,
    input logic          ready,
    input logic          full,
    input logic          half_full_n,
    input logic          test_null,
    input logic [CW-1:0] fifo_count,
    input tx_state_e     st
);

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CW'(DEPTH));

    p_full_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (full && (st == ST_DATA || st == ST_NULL)) |=> (fifo_count == CW'(DEPTH)));

    p_half_at_sixteen_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(half_full_n) |-> (fifo_count == CW'(DEPTH / 2)));

    p_ready_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!line_a && !line_b));

    p_null_half_r5: assert property (@(posedge clk) disable iff (rst)
        (st != ST_DATA) |-> (!line_a && !line_b));

    p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(line_a && line_b));

    p_test_forces_null_r11: assert property (@(posedge clk) disable iff (rst)
        test_null |-> (!line_a && !line_b));

endmodule

bind a429_tx_seq a429_tx_checker #(
    .DEPTH (DEPTH),
    .CW    (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .line_a      (line_a),
    .line_b      (line_b),
    .ready       (ready),
    .full        (full),
    .half_full_n (half_full_n),
    .test_null   (test_null),
    .fifo_count  (fifo_count),
    .st          (tx_state)
);

// File: tb/tb_a429_tx_seq.sv
`timescale 1ns/1ps
module tb_a429_tx_seq;

    localparam int HS_HALF = 5;
    localparam int LS_HALF = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_lo = 1'b0;
    logic        wr_hi = 1'b0;
    logic [15:0] wr_data = '0;
    logic        tx_enable = 1'b0;
    logic        rate_slow = 1'b0;
    logic        parity_en = 1'b0;
    logic        parity_even = 1'b0;
    logic        test_null = 1'b0;
    logic        line_a;
    logic        line_b;
    logic        ready;
    logic        half_full_n;
    logic        full;

    int checks = 0;
    int errors = 0;
    int exp_gap = 0;
    int bits_seen = 0;
    string word_tag = "R9";
    logic [31:0] exp_q[$];

    always #5 clk = ~clk;

    a429_tx_seq dut (
        .clk         (clk),
        .rst         (rst),
        .wr_lo       (wr_lo),
        .wr_hi       (wr_hi),
        .wr_data     (wr_data),
        .tx_enable   (tx_enable),
        .rate_slow   (rate_slow),
        .parity_en   (parity_en),
        .parity_even (parity_even),
        .test_null   (test_null),
        .line_a      (line_a),
        .line_b      (line_b),
        .ready       (ready),
        .half_full_n (half_full_n),
        .full        (full)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_word(input logic [31:0] w);
        logic [31:0] r;
        int ones;
        r = w;
        if (parity_en) begin
            ones = $countones(w[30:0]);
            if (parity_even) r[31] = (ones % 2 == 1);
            else             r[31] = (ones % 2 == 0);
        end
        return r;
    endfunction

    // Driver: write both halves, optionally record the expected word.
    task automatic load_word(input logic [31:0] w, input bit expect_it);
        @(negedge clk);
        wr_lo = 1'b1; wr_data = w[15:0];
        @(negedge clk);
        wr_lo = 1'b0; wr_hi = 1'b1; wr_data = w[31:16];
        @(negedge clk);
        wr_hi = 1'b0; wr_data = '0;
        if (expect_it) exp_q.push_back(model_word(w));
    endtask

    task automatic wait_ready(input int limit, input string req);
        int n;
        n = 0;
        while (!ready && n < limit) begin
            @(negedge clk);
            n++;
        end
        #1;
        chk(ready == 1'b1, req, {31'd0, ready}, 32'd1);
    endtask

    // Monitor: decode the line back into words and compare with the queue.
    initial begin : monitor
        logic [1:0]  prev;
        logic [1:0]  cur;
        logic [31:0] acc;
        int run;
        int nbits;
        int half;
        bit gap_armed;
        prev = 2'b00; run = 0; nbits = 0; acc = '0; gap_armed = 1'b0;
        forever begin
            @(negedge clk);
            #1;
            if (rst) begin
                prev = 2'b00; run = 0; nbits = 0; gap_armed = 1'b0;
                continue;
            end
            cur = {line_a, line_b};
            if (cur == 2'b11) chk(1'b0, "R6 both drives high", {30'd0, cur}, 32'd0);
            if (ready) gap_armed = 1'b0;
            if (cur == prev) begin
                run++;
            end else begin
                half = rate_slow ? LS_HALF : HS_HALF;
                if (prev != 2'b00) begin
                    chk(run == half, "R5 data half width", run, half);
                    acc[nbits] = (prev == 2'b10);
                    nbits++;
                    bits_seen++;
                    if (nbits == 32) begin
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R2 unexpected word on line", acc, 32'd0);
                        end else begin
                            chk(acc == exp_q[0], word_tag, acc, exp_q[0]);
                            void'(exp_q.pop_front());
                        end
                        nbits = 0;
                        gap_armed = 1'b1;
                    end
                end else begin
                    if (nbits != 0)
                        chk(run == half, "R5 null half width", run, half);
                    else if (gap_armed && exp_gap != 0)
                        chk(run == half + exp_gap, "R7 word gap", run, half + exp_gap);
                end
                run = 1;
                prev = cur;
            end
        end
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stimulus
        int nonnull;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R13 / R4: reset state
        chk(ready == 1'b1, "R4 ready after reset", {31'd0, ready}, 32'd1);
        chk(full == 1'b0, "R13 full after reset", {31'd0, full}, 32'd0);
        chk(half_full_n == 1'b1, "R13 half flag after reset", {31'd0, half_full_n}, 32'd1);
        chk({line_a, line_b} == 2'b00, "R13 line null after reset", {30'd0, line_a, line_b}, 32'd0);

        // R1: upper strobe alone is ignored
        @(negedge clk);
        wr_hi = 1'b1; wr_data = 16'hBEEF;
        @(negedge clk);
        wr_hi = 1'b0;
        #1;
        chk(ready == 1'b1, "R1 lone upper strobe ignored", {31'd0, ready}, 32'd1);

        // R4 + R10 + R9: one word, parity off, first bit timing
        word_tag = "R9 unchanged word";
        load_word(32'h1234_5671, 1'b1);
        #1;
        chk(ready == 1'b0, "R4 ready drops after commit", {31'd0, ready}, 32'd0);
        @(negedge clk);
        tx_enable = 1'b1;
        @(negedge clk); #2;
        chk({line_a, line_b} == 2'b10, "R10 first bit next cycle", {30'd0, line_a, line_b}, 32'h2);
        wait_ready(1000, "R4 ready after single word");
        chk(exp_q.size() == 0, "R9 word delivered", exp_q.size(), 0);
        tx_enable = 1'b0;

        // R8 odd parity, back to back at fast rate, R7 gap
        parity_en = 1'b1; parity_even = 1'b0; exp_gap = 40;
        word_tag = "R8 odd parity word";
        load_word(32'h0000_0003, 1'b1);
        load_word(32'hFFFF_FFFF, 1'b1);
        load_word(32'h8000_0000, 1'b1);
        @(negedge clk); tx_enable = 1'b1;
        wait_ready(3000, "R4 ready after odd burst");
        chk(exp_q.size() == 0, "R8 odd burst drained", exp_q.size(), 0);
        tx_enable = 1'b0;

        // R8 even parity
        parity_even = 1'b1;
        word_tag = "R8 even parity word";
        load_word(32'h0000_0001, 1'b1);
        load_word(32'h7FFF_FFFE, 1'b1);
        @(negedge clk); tx_enable = 1'b1;
        wait_ready(3000, "R4 ready after even burst");
        chk(exp_q.size() == 0, "R8 even burst drained", exp_q.size(), 0);
        tx_enable = 1'b0;

        // R5 / R7 slow rate
        parity_en = 1'b0; rate_slow = 1'b1; exp_gap = 320;
        word_tag = "R5 slow rate word";
        load_word(32'hA5A5_3C3C, 1'b1);
        load_word(32'h0F0F_F0F0, 1'b1);
        @(negedge clk); tx_enable = 1'b1;
        wait_ready(8000, "R4 ready after slow burst");
        chk(exp_q.size() == 0, "R5 slow burst drained", exp_q.size(), 0);
        tx_enable = 1'b0;
        rate_slow = 1'b0; exp_gap = 40;

        // R3 / R2: fill the queue
        word_tag = "R2 queued word";
        for (int i = 0; i < 15; i++) load_word(32'h1000_0000 + i * 32'h0101_0101, 1'b1);
        #1;
        chk(half_full_n == 1'b1, "R3 fifteen words", {31'd0, half_full_n}, 32'd1);
        load_word(32'h2222_0015, 1'b1);
        #1;
        chk(half_full_n == 1'b0, "R3 sixteen words", {31'd0, half_full_n}, 32'd0);
        chk(full == 1'b0, "R2 not full at sixteen", {31'd0, full}, 32'd0);
        for (int i = 16; i < 32; i++) load_word(32'h3000_0000 + i * 32'h0011_0003, 1'b1);
        #1;
        chk(full == 1'b1, "R2 full at thirty-two", {31'd0, full}, 32'd1);
        load_word(32'hDEAD_DEAD, 1'b0);
        #1;
        chk(full == 1'b1, "R2 still full after extra", {31'd0, full}, 32'd1);
        @(negedge clk); tx_enable = 1'b1;
        wait_ready(20000, "R4 ready after full drain");
        chk(exp_q.size() == 0, "R2 exactly thirty-two sent", exp_q.size(), 0);
        chk(half_full_n == 1'b1, "R3 flag clears when drained", {31'd0, half_full_n}, 32'd1);
        tx_enable = 1'b0;

        // R12: enable drops mid-word
        exp_gap = 0;
        word_tag = "R12 word";
        load_word(32'h5555_AAAA, 1'b1);
        load_word(32'h0123_4567, 1'b1);
        @(negedge clk); tx_enable = 1'b1;
        repeat (60) @(negedge clk);
        tx_enable = 1'b0;
        repeat (400) @(negedge clk);
        #1;
        chk(exp_q.size() == 1, "R12 current word finished only", exp_q.size(), 1);
        chk(ready == 1'b0, "R12 second word still queued", {31'd0, ready}, 32'd0);
        chk({line_a, line_b} == 2'b00, "R12 idle line null", {30'd0, line_a, line_b}, 32'd0);
        tx_enable = 1'b1;
        wait_ready(1000, "R12 ready after resume");
        chk(exp_q.size() == 0, "R12 resumed word sent", exp_q.size(), 0);
        tx_enable = 1'b0;

        // R11: test input forces null while draining continues
        test_null = 1'b1;
        load_word(32'hFFFF_FFFF, 1'b0);
        @(negedge clk); tx_enable = 1'b1;
        nonnull = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk); #1;
            if (line_a || line_b) nonnull++;
        end
        chk(nonnull == 0, "R11 line held null", nonnull, 0);
        wait_ready(500, "R11 word drained under test");
        test_null = 1'b0;
        tx_enable = 1'b0;

        // R13: reset mid-word and discard of captured lower half
        word_tag = "R13 word";
        load_word(32'h0F0F_0F0F, 1'b1);
        load_word(32'h3333_3333, 1'b1);
        @(negedge clk); tx_enable = 1'b1;
        repeat (50) @(negedge clk);
        wr_lo = 1'b1; wr_data = 16'h4444;
        @(negedge clk);
        wr_lo = 1'b0;
        rst = 1'b1;
        exp_q.delete();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(ready == 1'b1, "R13 queue emptied", {31'd0, ready}, 32'd1);
        chk({line_a, line_b} == 2'b00, "R13 line null after abort", {30'd0, line_a, line_b}, 32'd0);
        @(negedge clk);
        wr_hi = 1'b1; wr_data = 16'h5555;
        @(negedge clk);
        wr_hi = 1'b0;
        bits_seen = 0;
        repeat (200) @(negedge clk);
        #1;
        chk(ready == 1'b1, "R13 captured half discarded", {31'd0, ready}, 32'd1);
        chk(bits_seen == 0, "R13 nothing transmitted", bits_seen, 0);
        tx_enable = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule